// File: doc/BRIEF.md
# Interrupt Group Enable Register with Release Request

This block keeps the two enable flags that decide whether group 1 interrupts are taken, one flag for the secure state and one for the non-secure state. The flags sit in a 32-bit control word. A privileged monitor port reads and writes the whole word. Two single-bit alias ports each reach only the flag that belongs to their own security state. All three ports share the same storage, so a value written through one port is seen at once on the others. The upper thirty bits of the word are reserved: they read as zero, and anything written to them is dropped.

When a flag is turned off, an interrupt of that group may already be held in the CPU interface. If so, the block raises a one-cycle release request for that group. This lets the distributor take the interrupt back and hand it to another processing element, which is what a one-of-N interrupt needs. The pending flags come from the CPU interface. The release requests go back to the distributor side.

Top module: `irq_grp_enable`

## Requirements
- R1: After reset, both enable flags are 0, the full word reads 0, both alias reads are 0 and no release request is raised.
- R2: A monitor write updates the word on the clock edge that samples it. Bit 0 is the non-secure enable and bit 1 is the secure enable. A flag value of 1 means enabled and 0 means disabled. The `grpEnable` output uses the same bit order.
- R3: Bits 31 to 2 of the monitor read are always 0, whatever data is written to them.
- R4: Alias index 1 is the secure alias. Its read returns word bit 1. Its write changes only word bit 1 and leaves bit 0 as it was.
- R5: Alias index 0 is the non-secure alias. Its read returns word bit 0. Its write changes only word bit 0 and leaves bit 1 as it was.
- R6: Suppose a write clears a flag that was 1, and that group's pending input is high in the cycle of the write. Then `relReq` for that group is high for exactly the one cycle after that clock edge. Both groups can release in the same cycle.
- R7: No release request is raised in any of these cases: the group's pending input is low, the flag was already 0, or the flag is written to 1.
- R8: When a monitor write and an alias write arrive in the same cycle, the monitor data decides every bit, including the bit the alias targets.
- R9: In a cycle with no write enable asserted, the word holds its value, whatever appears on the write data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| monWrEn | input | 1 | Monitor word write strobe |
| monWrData | input | 32 | Monitor write data |
| monRdData | output | 32 | Monitor read of the full word |
| aliasWrEn | input | 2 | Alias write strobes (0 = non-secure, 1 = secure) |
| aliasWrData | input | 2 | Alias write values, one per state |
| aliasRdData | output | 2 | Alias reads, one per state |
| pending | input | 2 | Group interrupt pending in the CPU interface, per state |
| relReq | output | 2 | One-cycle release request, per state |
| grpEnable | output | 2 | Current enable flags, per state |

## Verification
The case that is hardest to reach is a release request. It needs three things to line up in one cycle: a flag that is currently set, a write that clears it, and the matching pending input held high during that write. The stimulus first sets the flag through one port, then presents the clearing write with pending already driven. It covers both groups falling together and each group falling alone. The negative cases are a clearing write with pending low and a clearing write to a flag that is already 0. Each of these should leave the request low, and the bench checks that it does.

// File: rtl/irq_grp_enable_pkg.sv
package irq_grp_enable_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_GRP = 2;
  localparam int GRP_NS  = 0;
  localparam int GRP_S   = 1;
  localparam logic [REG_W-1:0] RW_MASK = {{(REG_W-NUM_GRP){1'b0}}, {NUM_GRP{1'b1}}};

  typedef struct packed {
    logic               monWr;
    logic [REG_W-1:0]   monWord;
    logic [NUM_GRP-1:0] aliasHit;
    logic [NUM_GRP-1:0] aliasVal;
  } grp_strobe_t;
endpackage

// File: rtl/irq_grp_enable_ctrl.sv
module irq_grp_enable_ctrl
  import irq_grp_enable_pkg::*;
(
  input  logic               monWrEn,
  input  logic [REG_W-1:0]   monWrData,
  input  logic [NUM_GRP-1:0] aliasWrEn,
  input  logic [NUM_GRP-1:0] aliasWrData,
  output grp_strobe_t        strobe
);
  // The monitor write has priority: when it is present, every alias strobe is dropped.
  always_comb begin
    strobe.monWr    = monWrEn;
    strobe.monWord  = monWrData & RW_MASK;
    strobe.aliasHit = aliasWrEn & {NUM_GRP{~monWrEn}};
    strobe.aliasVal = aliasWrData;
  end
endmodule

// File: rtl/irq_grp_enable_dp.sv
module irq_grp_enable_dp
  import irq_grp_enable_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  grp_strobe_t        strobe,
  input  logic [NUM_GRP-1:0] pending,
  output logic [REG_W-1:0]   wordQ,
  output logic [NUM_GRP-1:0] relReq
);
  logic [REG_W-1:0]   wordD;
  logic [NUM_GRP-1:0] relD;

  // A monitor write replaces the whole word. Without one, each alias write overlays its own bit.
  always_comb begin
    wordD = strobe.monWr ? strobe.monWord : wordQ;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (strobe.aliasHit[g]) wordD[g] = strobe.aliasVal[g];
    end
    wordD = wordD & RW_MASK;
  end

  // A release is raised on a 1-to-0 change of a flag while that group has an interrupt pending.
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_rel
    assign relD[g] = wordQ[g] & ~wordD[g] & pending[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      relReq <= '0;
    end else begin
      wordQ  <= wordD;
      relReq <= relD;
    end
  end
endmodule

// File: rtl/irq_grp_enable.sv
module irq_grp_enable
  import irq_grp_enable_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               monWrEn,
  input  logic [REG_W-1:0]   monWrData,
  output logic [REG_W-1:0]   monRdData,
  input  logic [NUM_GRP-1:0] aliasWrEn,
  input  logic [NUM_GRP-1:0] aliasWrData,
  output logic [NUM_GRP-1:0] aliasRdData,
  input  logic [NUM_GRP-1:0] pending,
  output logic [NUM_GRP-1:0] relReq,
  output logic [NUM_GRP-1:0] grpEnable
);
  grp_strobe_t      strobe;
  logic [REG_W-1:0] wordQ;

  irq_grp_enable_ctrl u_ctrl (
    .monWrEn     (monWrEn),
    .monWrData   (monWrData),
    .aliasWrEn   (aliasWrEn),
    .aliasWrData (aliasWrData),
    .strobe      (strobe)
  );

  irq_grp_enable_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pending (pending),
    .wordQ   (wordQ),
    .relReq  (relReq)
  );

  assign monRdData   = wordQ;
  assign aliasRdData = wordQ[NUM_GRP-1:0];
  assign grpEnable   = wordQ[NUM_GRP-1:0];
endmodule

// File: rtl/irq_grp_enable_chk.sv
module irq_grp_enable_chk
  import irq_grp_enable_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               monWrEn,
  input logic [REG_W-1:0]   monWrData,
  input logic [REG_W-1:0]   monRdData,
  input logic [NUM_GRP-1:0] aliasWrEn,
  input logic [NUM_GRP-1:0] aliasWrData,
  input logic [NUM_GRP-1:0] aliasRdData,
  input logic [NUM_GRP-1:0] pending,
  input logic [NUM_GRP-1:0] relReq,
  input logic [NUM_GRP-1:0] grpEnable
);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    monRdData[REG_W-1:NUM_GRP] == '0);

  assert_monitor_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    monWrEn |=> grpEnable == $past(monWrData[NUM_GRP-1:0]));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!monWrEn && aliasWrEn == '0) |=> $stable(monRdData));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // R4 and R5: the alias read follows the shared word bit
    assert_alias_view_R4_R5: assert property (@(posedge clk) disable iff (!rstN)
      aliasRdData[g] == monRdData[g]);

    assert_alias_write_R5: assert property (@(posedge clk) disable iff (!rstN)
      (aliasWrEn[g] && !monWrEn) |=> grpEnable[g] == $past(aliasWrData[g]));

    assert_fall_releases_R6: assert property (@(posedge clk) disable iff (!rstN)
      (grpEnable[g] && pending[g] && (monWrEn ? !monWrData[g] : (aliasWrEn[g] && !aliasWrData[g])))
      |=> relReq[g]);

    assert_release_single_R6: assert property (@(posedge clk) disable iff (!rstN)
      relReq[g] |=> !relReq[g]);

    assert_release_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      relReq[g] |-> (!grpEnable[g] && $past(grpEnable[g]) && $past(pending[g])));
  end
endmodule

bind irq_grp_enable irq_grp_enable_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .monWrEn     (monWrEn),
  .monWrData   (monWrData),
  .monRdData   (monRdData),
  .aliasWrEn   (aliasWrEn),
  .aliasWrData (aliasWrData),
  .aliasRdData (aliasRdData),
  .pending     (pending),
  .relReq      (relReq),
  .grpEnable   (grpEnable)
);

// File: tb/irq_grp_enable_bench.sv
module irq_grp_enable_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        monWrEn = 1'b0;
  logic [31:0] monWrData = '0;
  logic [31:0] monRdData;
  logic [1:0]  aliasWrEn = '0;
  logic [1:0]  aliasWrData = '0;
  logic [1:0]  aliasRdData;
  logic [1:0]  pending = '0;
  logic [1:0]  relReq;
  logic [1:0]  grpEnable;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_grp_enable u_irq_grp_enable (
    .clk(clk), .rstN(rstN), .monWrEn(monWrEn), .monWrData(monWrData),
    .monRdData(monRdData), .aliasWrEn(aliasWrEn), .aliasWrData(aliasWrData),
    .aliasRdData(aliasRdData), .pending(pending), .relReq(relReq), .grpEnable(grpEnable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Inputs change one time unit after a rising edge. Results are sampled at that same point after the next edge.
  task automatic step(input logic mwe, input logic [31:0] mwd, input logic [1:0] awe,
                      input logic [1:0] awd, input logic [1:0] pend);
    monWrEn = mwe; monWrData = mwd; aliasWrEn = awe; aliasWrData = awd; pending = pend;
    @(posedge clk); #1;
    monWrEn = 1'b0; aliasWrEn = '0;
  endtask

  task automatic idle(input logic [1:0] pend);
    step(1'b0, 32'hA5A5_5A5A, 2'b00, 2'b11, pend);
  endtask

  task automatic tReset;
    check("R1 word", monRdData, 32'h0);
    check("R1 alias", {30'h0, aliasRdData}, 32'h0);
    check("R1 enable", {30'h0, grpEnable}, 32'h0);
    check("R1 release", {30'h0, relReq}, 32'h0);
  endtask

  task automatic tMonitor;
    step(1'b1, 32'hFFFF_FFFF, 2'b00, 2'b00, 2'b00);
    check("R3 reserved bits read zero", monRdData, 32'h3);
    step(1'b1, 32'h0000_0001, 2'b00, 2'b00, 2'b00);
    check("R2 bit0 is non-secure", {30'h0, grpEnable}, 32'h1);
    step(1'b1, 32'hFFFF_FFFE, 2'b00, 2'b00, 2'b00);
    check("R2 bit1 is secure", monRdData, 32'h2);
    check("R7 no release without pending", {30'h0, relReq}, 32'h0);
  endtask

  task automatic tAlias;
    step(1'b0, 32'h0, 2'b01, 2'b01, 2'b00);
    check("R5 non-secure alias write", monRdData, 32'h3);
    step(1'b0, 32'h0, 2'b10, 2'b00, 2'b00);
    check("R4 secure alias write", monRdData, 32'h1);
    check("R4 R5 alias read", {30'h0, aliasRdData}, 32'h1);
  endtask

  task automatic tRelease;
    step(1'b1, 32'h3, 2'b00, 2'b00, 2'b11);
    check("R7 no release on set", {30'h0, relReq}, 32'h0);
    step(1'b1, 32'h0, 2'b00, 2'b00, 2'b11);
    check("R6 both groups release", {30'h0, relReq}, 32'h3);
    idle(2'b11);
    check("R6 release lasts one cycle", {30'h0, relReq}, 32'h0);
    step(1'b1, 32'h3, 2'b00, 2'b00, 2'b00);
    step(1'b0, 32'h0, 2'b10, 2'b00, 2'b10);
    check("R6 secure alias clear releases", {30'h0, relReq}, 32'h2);
    step(1'b0, 32'h0, 2'b01, 2'b00, 2'b00);
    check("R7 clear without pending", {30'h0, relReq}, 32'h0);
    step(1'b1, 32'h0, 2'b00, 2'b00, 2'b11);
    check("R7 already clear", {30'h0, relReq}, 32'h0);
  endtask

  task automatic tPriority;
    step(1'b1, 32'h3, 2'b11, 2'b00, 2'b00);
    check("R8 monitor beats alias clear", monRdData, 32'h3);
    step(1'b1, 32'h0, 2'b11, 2'b11, 2'b00);
    check("R8 monitor beats alias set", monRdData, 32'h0);
  endtask

  task automatic tHold;
    step(1'b1, 32'h2, 2'b00, 2'b00, 2'b00);
    idle(2'b11);
    idle(2'b00);
    check("R9 hold without enable", monRdData, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset;
    rstN = 1'b1;
    tMonitor;
    tAlias;
    tRelease;
    tPriority;
    tHold;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule